// File: doc/BRIEF.md
# Residue-Coded Fault-Tolerant S-Box Substitution

This block applies the AES byte substitution to a value that is never held as a plain byte. It is held as two 4-bit residues. Over GF(2), a byte b is read as a polynomial, with bit i the coefficient of x^i. The first residue is b reduced modulo x^4+x+1. The second is b reduced modulo x^4+x^3+1. The two moduli are coprime, so the pair names exactly one byte.

The substitution uses four tables, each indexed by the residue pair:

- Two tables give the residues of the substituted byte.
- Two tables give control residues, formed modulo the control polynomial x^4+x^3+x^2+x+1.

A check stage recomputes the control residues from the informational residues that were read out. It XORs each recomputed value with the matching table value to form a two-part syndrome. That syndrome locates a faulty residue and repairs it.

A fault-injection mask can be XORed onto each looked-up informational residue. This lets a bench or a built-in test model read faults in the tables. The result is registered, and flags report whether a repair was made or whether the word could not be repaired.

Top module: `rsb_ft_subbytes`

## Requirements
- R1: Outputs are registered with one cycle of latency. While rst_n is low, every output is zero, and a new input does not reach the outputs before the next rising clock edge.
- R2: Inputs in_ra and in_rb encode byte b as (b mod x^4+x+1, b mod x^4+x^3+1), with bit i the coefficient of x^i. Without faults, out_ra and out_rb give the same two residues of S(b), where S is the standard AES S-box.
- R3: out_ca equals the fault-free output residue ra reduced modulo x^4+x^3+x^2+x+1 (weight 1). out_cb equals x times the fault-free output residue rb, modulo the same polynomial. Both come from the control tables and do not change with the fault masks.
- R4: flt_ra is XORed onto the looked-up ra and flt_rb onto the looked-up rb before the check stage.
- R5: With both masks zero, err_fixed and err_uncorr are both 0.
- R6: A nonzero flt_ra with a zero flt_rb gives a first syndrome part equal to the fault. That part is XORed back, so out_ra is the fault-free value and err_fixed is 1.
- R7: A nonzero flt_rb with a zero flt_ra gives a second syndrome part equal to x times the fault. Multiplying that part by x^-1 modulo the control polynomial recovers the fault vector, so out_rb is the fault-free value and err_fixed is 1.
- R8: When both masks are nonzero, both syndrome parts are nonzero. err_uncorr is then 1, err_fixed is 0, and out_ra and out_rb pass through unchanged as the faulty residues.
- R9: err_fixed and err_uncorr are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_ra | input | 4 | Input byte residue modulo x^4+x+1 |
| in_rb | input | 4 | Input byte residue modulo x^4+x^3+1 |
| flt_ra | input | 4 | Fault mask XORed onto the looked-up first residue |
| flt_rb | input | 4 | Fault mask XORed onto the looked-up second residue |
| out_ra | output | 4 | Corrected first residue of the substituted byte |
| out_rb | output | 4 | Corrected second residue of the substituted byte |
| out_ca | output | 4 | First control residue from the table |
| out_cb | output | 4 | Second control residue from the table |
| err_fixed | output | 1 | A single-residue fault was located and repaired |
| err_uncorr | output | 1 | Both syndrome parts were nonzero; the data was left as read |

## Verification
The bench checks all 256 input bytes against an S-box it derives on its own, so a CRT or table-indexing slip shows up as wrong residues. It injects every nonzero fault pattern into each residue in turn:

- A design that swapped which syndrome part points at which residue would corrupt the healthy residue.
- A design that repaired the second residue with the raw syndrome, instead of dividing it by x, would leave wrong bits in most cases.

Double faults check that the data passes through unchanged and that only the uncorrectable flag rises. A design that tried a repair there would produce residues that differ from the faulty pair.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int RW = 4;
    localparam int BW = 8;
    localparam int ENTRIES = 1 << (2 * RW);

    localparam logic [RW:0] MOD_A = 5'b10011;
    localparam logic [RW:0] MOD_B = 5'b11001;
    localparam logic [RW:0] MOD_C = 5'b11111;

    typedef struct packed {
        logic [RW-1:0] ra;
        logic [RW-1:0] rb;
        logic [RW-1:0] ca;
        logic [RW-1:0] cb;
        logic          fixed;
        logic          uncorr;
    } rsb_state_t;

    function automatic logic [RW-1:0] poly_rem(input logic [BW-1:0] val, input logic [RW:0] m);
        logic [BW-1:0] acc;
        acc = val;
        for (int k = BW - 1; k >= RW; k--) begin
            if (acc[k]) acc = acc ^ (BW'(m) << (k - RW));
        end
        return acc[RW-1:0];
    endfunction

    function automatic logic [BW-1:0] gf_mul(input logic [BW-1:0] a, input logic [BW-1:0] b);
        logic [BW-1:0] p;
        logic [BW-1:0] t;
        p = '0;
        t = a;
        for (int i = 0; i < BW; i++) begin
            if (b[i]) p = p ^ t;
            t = t[BW-1] ? ({t[BW-2:0], 1'b0} ^ 8'h1B) : {t[BW-2:0], 1'b0};
        end
        return p;
    endfunction

    function automatic logic [BW-1:0] gf_inv(input logic [BW-1:0] a);
        logic [BW-1:0] r;
        logic [BW-1:0] base;
        logic [BW-1:0] e;
        r    = 8'h01;
        base = a;
        e    = 8'd254;
        for (int i = 0; i < BW; i++) begin
            if (e[i]) r = gf_mul(r, base);
            base = gf_mul(base, base);
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] aes_sbox(input logic [BW-1:0] a);
        logic [BW-1:0] v;
        v = gf_inv(a);
        return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
                 ^ {v[3:0], v[7:4]} ^ 8'h63;
    endfunction

    function automatic logic [BW-1:0] crt_join(input logic [RW-1:0] ra, input logic [RW-1:0] rb,
                                               input logic [RW:0] ma, input logic [RW:0] mb);
        logic [BW-1:0] hit;
        hit = '0;
        for (int b = 0; b < (1 << BW); b++) begin
            if (poly_rem(BW'(b), ma) == ra && poly_rem(BW'(b), mb) == rb) hit = BW'(b);
        end
        return hit;
    endfunction

    function automatic logic [RW-1:0] ctl_reduce(input logic [RW-1:0] c, input logic [RW:0] m);
        return (c >= m[RW-1:0] && m[RW-1:0] == '0) ? '0 : c;
    endfunction

    function automatic logic [RW-1:0] ctl_mulx(input logic [RW-1:0] c, input logic [RW:0] m);
        return {c[RW-2:0], 1'b0} ^ (c[RW-1] ? m[RW-1:0] : '0);
    endfunction

    function automatic logic [RW-1:0] ctl_divx(input logic [RW-1:0] c, input logic [RW:0] m);
        logic [RW:0] t;
        t = c[0] ? ({1'b0, c} ^ m) : {1'b0, c};
        return t[RW:1];
    endfunction

endpackage

// File: rtl/rsb_table.sv
module rsb_table
    import rsb_pkg::*;
#(
    parameter logic [RW:0] MA = MOD_A,
    parameter logic [RW:0] MB = MOD_B,
    parameter logic [RW:0] MC = MOD_C
) (
    input  logic [RW-1:0] idx_ra,
    input  logic [RW-1:0] idx_rb,
    output logic [RW-1:0] lk_ra,
    output logic [RW-1:0] lk_rb,
    output logic [RW-1:0] lk_ca,
    output logic [RW-1:0] lk_cb
);

    localparam int SIDE = 1 << RW;

    logic [RW-1:0] tab_ra [ENTRIES];
    logic [RW-1:0] tab_rb [ENTRIES];
    logic [RW-1:0] tab_ca [ENTRIES];
    logic [RW-1:0] tab_cb [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        localparam logic [RW-1:0] IA = RW'(i % SIDE);
        localparam logic [RW-1:0] IB = RW'(i / SIDE);
        localparam logic [BW-1:0] PLAIN = crt_join(IA, IB, MA, MB);
        localparam logic [BW-1:0] SUBST = aes_sbox(PLAIN);
        localparam logic [RW-1:0] OA = poly_rem(SUBST, MA);
        localparam logic [RW-1:0] OB = poly_rem(SUBST, MB);
        assign tab_ra[i] = OA;
        assign tab_rb[i] = OB;
        assign tab_ca[i] = ctl_reduce(OA, MC);
        assign tab_cb[i] = ctl_mulx(OB, MC);
    end

    logic [2*RW-1:0] sel;
    assign sel   = {idx_rb, idx_ra};
    assign lk_ra = tab_ra[sel];
    assign lk_rb = tab_rb[sel];
    assign lk_ca = tab_ca[sel];
    assign lk_cb = tab_cb[sel];

endmodule

// File: rtl/rsb_syndrome.sv
module rsb_syndrome
    import rsb_pkg::*;
#(
    parameter logic [RW:0] MC = MOD_C
) (
    input  logic [RW-1:0] rd_ra,
    input  logic [RW-1:0] rd_rb,
    input  logic [RW-1:0] tb_ca,
    input  logic [RW-1:0] tb_cb,
    output logic [RW-1:0] syn_a,
    output logic [RW-1:0] syn_b
);

    logic [RW-1:0] re_ca;
    logic [RW-1:0] re_cb;

    always_comb begin
        re_ca = ctl_reduce(rd_ra, MC);
        re_cb = ctl_mulx(rd_rb, MC);
        syn_a = re_ca ^ tb_ca;
        syn_b = re_cb ^ tb_cb;
    end

endmodule

// File: rtl/rsb_correct.sv
module rsb_correct
    import rsb_pkg::*;
#(
    parameter logic [RW:0] MC = MOD_C
) (
    input  logic [RW-1:0] rd_ra,
    input  logic [RW-1:0] rd_rb,
    input  logic [RW-1:0] syn_a,
    input  logic [RW-1:0] syn_b,
    output logic [RW-1:0] fx_ra,
    output logic [RW-1:0] fx_rb,
    output logic          fixed,
    output logic          uncorr
);

    logic          nz_a;
    logic          nz_b;
    logic [RW-1:0] evec_a;
    logic [RW-1:0] evec_b;

    always_comb begin
        nz_a   = |syn_a;
        nz_b   = |syn_b;
        evec_a = (nz_a && !nz_b) ? syn_a : '0;
        evec_b = (nz_b && !nz_a) ? ctl_divx(syn_b, MC) : '0;
        fx_ra  = rd_ra ^ evec_a;
        fx_rb  = rd_rb ^ evec_b;
        fixed  = nz_a ^ nz_b;
        uncorr = nz_a & nz_b;
    end

endmodule

// File: rtl/rsb_ft_subbytes.sv
module rsb_ft_subbytes
    import rsb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] in_ra,
    input  logic [3:0] in_rb,
    input  logic [3:0] flt_ra,
    input  logic [3:0] flt_rb,
    output logic [3:0] out_ra,
    output logic [3:0] out_rb,
    output logic [3:0] out_ca,
    output logic [3:0] out_cb,
    output logic       err_fixed,
    output logic       err_uncorr
);

    logic [RW-1:0] lk_ra, lk_rb, lk_ca, lk_cb;
    logic [RW-1:0] rd_ra, rd_rb;
    logic [RW-1:0] syn_a, syn_b;
    logic [RW-1:0] fx_ra, fx_rb;
    logic          fixed, uncorr;

    rsb_state_t st_d, st_q;

    rsb_table #(.MA(MOD_A), .MB(MOD_B), .MC(MOD_C)) i_table (
        .idx_ra(in_ra), .idx_rb(in_rb),
        .lk_ra(lk_ra), .lk_rb(lk_rb), .lk_ca(lk_ca), .lk_cb(lk_cb)
    );

    assign rd_ra = lk_ra ^ flt_ra;
    assign rd_rb = lk_rb ^ flt_rb;

    rsb_syndrome #(.MC(MOD_C)) i_syn (
        .rd_ra(rd_ra), .rd_rb(rd_rb), .tb_ca(lk_ca), .tb_cb(lk_cb),
        .syn_a(syn_a), .syn_b(syn_b)
    );

    rsb_correct #(.MC(MOD_C)) i_fix (
        .rd_ra(rd_ra), .rd_rb(rd_rb), .syn_a(syn_a), .syn_b(syn_b),
        .fx_ra(fx_ra), .fx_rb(fx_rb), .fixed(fixed), .uncorr(uncorr)
    );

    always_comb begin
        st_d        = st_q;
        st_d.ra     = fx_ra;
        st_d.rb     = fx_rb;
        st_d.ca     = lk_ca;
        st_d.cb     = lk_cb;
        st_d.fixed  = fixed;
        st_d.uncorr = uncorr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_ra     = st_q.ra;
    assign out_rb     = st_q.rb;
    assign out_ca     = st_q.ca;
    assign out_cb     = st_q.cb;
    assign err_fixed  = st_q.fixed;
    assign err_uncorr = st_q.uncorr;

endmodule

// File: rtl/rsb_ft_subbytes_chk.sv
module rsb_ft_subbytes_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] flt_ra,
    input logic [3:0] flt_rb,
    input logic [3:0] out_ra,
    input logic [3:0] out_rb,
    input logic [3:0] out_ca,
    input logic [3:0] out_cb,
    input logic       err_fixed,
    input logic       err_uncorr
);

    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (out_ra == 4'h0 && out_rb == 4'h0 && out_ca == 4'h0
                          && out_cb == 4'h0 && !err_fixed && !err_uncorr));

    a_r5_clean_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_ra == 4'h0 && flt_rb == 4'h0) |=> (!err_fixed && !err_uncorr));

    a_r6_ra_fault_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_ra != 4'h0 && flt_rb == 4'h0) |=> (err_fixed && !err_uncorr));

    a_r7_rb_fault_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_rb != 4'h0 && flt_ra == 4'h0) |=> (err_fixed && !err_uncorr));

    a_r8_double_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_ra != 4'h0 && flt_rb != 4'h0) |=> (err_uncorr && !err_fixed));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({err_fixed, err_uncorr}) <= 1);

endmodule

bind rsb_ft_subbytes rsb_ft_subbytes_chk i_chk (
    .clk(clk), .rst_n(rst_n), .flt_ra(flt_ra), .flt_rb(flt_rb),
    .out_ra(out_ra), .out_rb(out_rb), .out_ca(out_ca), .out_cb(out_cb),
    .err_fixed(err_fixed), .err_uncorr(err_uncorr)
);

// File: tb/test_rsb_ft_subbytes.sv
module test_rsb_ft_subbytes;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] in_ra = '0, in_rb = '0, flt_ra = '0, flt_rb = '0;
    logic [3:0] out_ra, out_rb, out_ca, out_cb;
    logic       err_fixed, err_uncorr;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rsb_ft_subbytes i_rsb_ft_subbytes (
        .clk(clk), .rst_n(rst_n), .in_ra(in_ra), .in_rb(in_rb),
        .flt_ra(flt_ra), .flt_rb(flt_rb), .out_ra(out_ra), .out_rb(out_rb),
        .out_ca(out_ca), .out_cb(out_cb), .err_fixed(err_fixed), .err_uncorr(err_uncorr)
    );

    // byte, expected S-box value
    localparam logic [15:0] VEC [10] = '{16'h0063, 16'h017C, 16'h0277, 16'h037B, 16'h10CA,
                                         16'h53ED, 16'hFF16, 16'h9060, 16'h0F76, 16'hF08C};

    function automatic logic [3:0] m_rem(input logic [7:0] v, input logic [4:0] m);
        logic [7:0] a;
        a = v;
        for (int k = 7; k >= 4; k--) if (a[k]) a = a ^ ({3'b0, m} << (k - 4));
        return a[3:0];
    endfunction

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ ({8'b0, a} << i);
        for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011B << (k - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] a);
        logic [7:0] v, s;
        v = 8'h00;
        for (int c = 1; c < 256; c++) if (m_mul(a, 8'(c)) == 8'h01) v = 8'(c);
        for (int i = 0; i < 8; i++)
            s[i] = v[i] ^ v[(i + 4) % 8] ^ v[(i + 5) % 8] ^ v[(i + 6) % 8] ^ v[(i + 7) % 8];
        return s ^ 8'h63;
    endfunction

    function automatic logic [3:0] m_xc(input logic [3:0] c);
        return {c[2:0], 1'b0} ^ (c[3] ? 4'hF : 4'h0);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] b, input logic [7:0] s, input logic [3:0] fa,
                       input logic [3:0] fb);
        logic [3:0] ca, cb;
        ca = m_rem(s, 5'b10011);
        cb = m_rem(s, 5'b11001);
        @(negedge clk);
        in_ra  = m_rem(b, 5'b10011);
        in_rb  = m_rem(b, 5'b11001);
        flt_ra = fa;
        flt_rb = fb;
        @(negedge clk);
        chk("R3 ctl_a", {4'h0, out_ca}, {4'h0, ca});
        chk("R3 ctl_b", {4'h0, out_cb}, {4'h0, m_xc(cb)});
        chk("R9 excl", {7'h0, err_fixed & err_uncorr}, 8'h00);
        if (fa == 0 && fb == 0) begin
            chk("R2 data", {out_rb, out_ra}, {cb, ca});
            chk("R5 flags", {6'h0, err_fixed, err_uncorr}, 8'h00);
        end else if (fb == 0) begin
            chk("R6 data", {out_rb, out_ra}, {cb, ca});
            chk("R6 flags", {6'h0, err_fixed, err_uncorr}, 8'h02);
        end else if (fa == 0) begin
            chk("R7 data", {out_rb, out_ra}, {cb, ca});
            chk("R7 flags", {6'h0, err_fixed, err_uncorr}, 8'h02);
        end else begin
            chk("R8 R4 data", {out_rb, out_ra}, {cb ^ fb, ca ^ fa});
            chk("R8 flags", {6'h0, err_fixed, err_uncorr}, 8'h01);
        end
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        in_ra = 4'h5;
        in_rb = 4'h9;
        repeat (3) @(negedge clk);
        // R1: held in reset, outputs all zero
        chk("R1 reset", {out_rb, out_ra}, 8'h00);
        chk("R1 reset ctl", {out_cb, out_ca}, 8'h00);
        chk("R1 reset flags", {6'h0, err_fixed, err_uncorr}, 8'h00);
        rst_n = 1'b1;

        foreach (VEC[i]) run(VEC[i][15:8], VEC[i][7:0], 4'h0, 4'h0);

        // R1: latency, a changed input is not visible before the edge
        run(8'h53, 8'hED, 4'h0, 4'h0);
        in_ra = m_rem(8'h00, 5'b10011);
        in_rb = m_rem(8'h00, 5'b11001);
        #1;
        chk("R1 latency", {out_rb, out_ra}, {m_rem(8'hED, 5'b11001), m_rem(8'hED, 5'b10011)});

        for (int b = 0; b < 256; b++) run(8'(b), m_sbox(8'(b)), 4'h0, 4'h0);

        for (int j = 0; j < 4; j++) begin
            logic [7:0] b;
            b = (j == 0) ? 8'h00 : (j == 1) ? 8'h8E : (j == 2) ? 8'h3C : 8'hFF;
            for (int f = 1; f < 16; f++) run(b, m_sbox(b), 4'(f), 4'h0);
            for (int f = 1; f < 16; f++) run(b, m_sbox(b), 4'h0, 4'(f));
        end

        for (int fa = 1; fa < 16; fa++)
            for (int fb = 1; fb < 16; fb++) run(8'h90, 8'h60, 4'(fa), 4'(fb));

        run(8'hC0, m_sbox(8'hC0), 4'h0, 4'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule